// File: doc/BRIEF.md
# Serial Control Bus Register Slave

This block is the device side of a three-wire control bus: an active-low select, a bus clock driven by the master, and one shared data line. The master lowers select and clocks out a 9-bit header word, most significant bit first. The header names a target device, a transfer direction and a register index. A 16-bit data word follows. On a write the master shifts the word in. On a read the slave shifts the addressed register out on the same line. Once the data word ends, a new header may follow at once, without select being raised.

All three bus pins pass through a two-flop synchroniser into the system clock domain. Bus clock rising edges are detected on the synchronised copy. Toward local logic the block offers a plain register port: a register index, a one-cycle read strobe with a combinational return word, and a one-cycle write strobe with its data. The slave answers only headers whose device field equals its build-time address, and it enables its data driver only while it returns read data.

Top module: `sbus_slave`

## Requirements
- R1: After reset, with select high, the read strobe, write strobe, drive enable and data output are all 0.
- R2: Only rising edges of the bus clock taken while select is low are counted. The first 9 form the header, most significant bit first: bits 8:6 are the device address, bit 5 is the direction (1 = read, 0 = write) and bits 4:0 are the register index.
- R3: A read header whose device address equals DEV_ADDR gives one read strobe with reg_idx set to the header's index. The returned word then appears on bus_dout, most significant bit first, one bit per data-phase rising edge, over 16 edges.
- R4: A write header whose device address matches is followed by 16 data bits, most significant first. After the 16th bit comes exactly one write strobe carrying the header's index and the assembled word. No strobe comes earlier.
- R5: A header with any other device address produces no strobe. The slave leaves reg_idx unchanged and keeps bus_doe and bus_dout at 0 through its data phase.
- R6: bus_doe rises on the header edge of a matching read. It holds through all 16 data bits and drops at the next bus clock rising edge or when select goes high.
- R7: After the 16th data bit the slave expects a new 9-bit header while select stays low, so frames can be chained back to back.
- R8: Raising select in the middle of a frame abandons it without any strobe. The next frame after select falls starts again at header bit 8.
- R9: Bus clock edges while select is high have no effect.
- R10: A strobe caused by a bus clock rising edge is high during the cycle after the third system clock edge that follows the pin change. It lasts exactly one cycle.
- R11: Read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_clk | input | 1 | Bus clock from the master |
| bus_din | input | 1 | Data line as seen by the slave |
| bus_dout | output | 1 | Data bit the slave drives |
| bus_doe | output | 1 | Drive enable for the data line |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_idx | output | 5 | Register index of the current access |
| reg_wdata | output | 16 | Write data, valid with reg_wr |
| reg_rdata | input | 16 | Read data returned for reg_idx, sampled the cycle after reg_rd |

## Verification
A pin change reaches the frame logic three system clock edges later. Two of those edges are the synchroniser and one is the framer register, so every result trails the bus by three system cycles. The bench holds each bus clock half period for four system cycles and samples bus_dout and bus_doe only at the end of a half period, when the result of the preceding edge has settled. One write is checked edge by edge on the system clock: the strobe must be low after the second edge, high after the third and low again after the fourth. The other strobe checks compare counts taken while the bus is idle.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    // Header and data word geometry.
    localparam int unsigned DEV_W  = 3;
    localparam int unsigned IDX_W  = 5;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned HDR_W  = DEV_W + 1 + IDX_W;
    localparam int unsigned LONG_W = (HDR_W > WORD_W) ? HDR_W : WORD_W;
    localparam int unsigned CNT_W  = $clog2(LONG_W);

    // Positions of the bus pins inside the synchronised vector.
    localparam int unsigned PIN_SEL = 0;
    localparam int unsigned PIN_CLK = 1;
    localparam int unsigned PIN_DAT = 2;
    localparam int unsigned PIN_N   = 3;

    typedef enum logic {
        PH_HDR  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // Field order is significant: device ID in the top bits.
    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic             rd;
        logic [IDX_W-1:0] idx;
    } hdr_t;

    typedef logic [CNT_W-1:0] cnt_t;

    function automatic cnt_t last_index(int unsigned width);
        return cnt_t'(width - 1);
    endfunction

endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
    parameter int unsigned   W       = 3,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int unsigned CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[CHAIN_W-W-1:0], d};
            end
        end
    endgenerate

    assign q = chain[CHAIN_W-1 -: W];

endmodule

// File: rtl/sbus_edge.sv
module sbus_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;

endmodule

// File: rtl/sbus_framer.sv
module sbus_framer
    import sbus_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = 3'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_act,
    input  logic              bit_rise,
    input  logic              din,
    input  logic [WORD_W-1:0] rdata,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] wdata,
    output logic              dout,
    output logic              doe
);
    phase_e            phase;
    cnt_t              cnt;
    logic [WORD_W-1:0] shreg;
    logic              hit;
    logic              is_rd;

    logic [WORD_W-1:0] shifted;
    hdr_t              hdr_now;
    logic              hdr_match;
    logic              cnt_done;

    assign shifted   = {shreg[WORD_W-2:0], din};
    assign hdr_now   = hdr_t'(shifted[HDR_W-1:0]);
    assign hdr_match = (hdr_now.dev == DEV_ADDR);
    assign cnt_done  = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_HDR;
            cnt    <= last_index(HDR_W);
            shreg  <= '0;
            hit    <= 1'b0;
            is_rd  <= 1'b0;
            doe    <= 1'b0;
            dout   <= 1'b0;
            rd_stb <= 1'b0;
            wr_stb <= 1'b0;
            idx    <= '0;
            wdata  <= '0;
        end else begin
            rd_stb <= 1'b0;
            wr_stb <= 1'b0;
            if (!sel_act) begin
                // Deselected: park in the header phase.
                phase <= PH_HDR;
                cnt   <= last_index(HDR_W);
                shreg <= '0;
                hit   <= 1'b0;
                is_rd <= 1'b0;
                doe   <= 1'b0;
                dout  <= 1'b0;
            end else if (rd_stb) begin
                // Returned word is captured one cycle after the strobe.
                shreg <= rdata;
            end else if (bit_rise) begin
                unique case (phase)
                    PH_HDR: begin
                        doe  <= 1'b0;
                        dout <= 1'b0;
                        if (cnt_done) begin
                            phase  <= PH_DATA;
                            cnt    <= last_index(WORD_W);
                            shreg  <= '0;
                            hit    <= hdr_match;
                            is_rd  <= hdr_now.rd;
                            doe    <= hdr_match & hdr_now.rd;
                            rd_stb <= hdr_match & hdr_now.rd;
                            if (hdr_match) idx <= hdr_now.idx;
                        end else begin
                            cnt   <= cnt - 1'b1;
                            shreg <= shifted;
                        end
                    end
                    PH_DATA: begin
                        if (is_rd) begin
                            dout  <= shreg[WORD_W-1] & hit;
                            shreg <= shreg << 1;
                        end else begin
                            shreg <= shifted;
                        end
                        if (cnt_done) begin
                            phase <= PH_HDR;
                            cnt   <= last_index(HDR_W);
                            shreg <= '0;
                            if (hit && !is_rd) begin
                                wr_stb <= 1'b1;
                                wdata  <= shifted;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));

    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R4
    wr_last_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (phase == PH_HDR) && $past(bit_rise));

    // R3
    rd_doe_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> doe && (phase == PH_DATA));

    // R5
    doe_hit_chk: assert property (@(posedge clk) disable iff (rst)
        doe |-> hit && is_rd);

    // R6
    doe_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_act |=> !doe && (phase == PH_HDR));

    // R2
    hdr_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HDR) |-> (cnt <= last_index(HDR_W)));

endmodule

// File: rtl/sbus_slave.sv
module sbus_slave
    import sbus_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR    = 3'd1,
    parameter int unsigned      SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel_n,
    input  logic              bus_clk,
    input  logic              bus_din,
    output logic              bus_dout,
    output logic              bus_doe,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata
);
    localparam logic [PIN_N-1:0] PIN_IDLE = PIN_N'(1 << PIN_SEL);

    logic [PIN_N-1:0] pins_raw;
    logic [PIN_N-1:0] pins_s;
    logic             bit_rise;

    assign pins_raw[PIN_SEL] = bus_sel_n;
    assign pins_raw[PIN_CLK] = bus_clk;
    assign pins_raw[PIN_DAT] = bus_din;

    sbus_sync #(
        .W       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    sbus_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (pins_s[PIN_CLK]),
        .rise (bit_rise)
    );

    sbus_framer #(
        .DEV_ADDR (DEV_ADDR)
    ) u_framer (
        .clk      (clk),
        .rst      (rst),
        .sel_act  (~pins_s[PIN_SEL]),
        .bit_rise (bit_rise),
        .din      (pins_s[PIN_DAT]),
        .rdata    (reg_rdata),
        .rd_stb   (reg_rd),
        .wr_stb   (reg_wr),
        .idx      (reg_idx),
        .wdata    (reg_wdata),
        .dout     (bus_dout),
        .doe      (bus_doe)
    );

endmodule

// File: tb/sbus_slave_bench.sv
module sbus_slave_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         HALF       = 4;
    localparam logic [2:0] MY_DEV     = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        bclk = 1'b0;
    logic        bdat = 1'b0;
    logic        dout, doe, rd, wr;
    logic [4:0]  idx;
    logic [15:0] wdata, rdata;

    int n_chk = 0;
    int n_err = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int doe_cnt = 0;
    logic [4:0]  rd_idx_seen = '0;
    logic [4:0]  wr_idx_seen = '0;
    logic [15:0] wr_data_seen = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] rmodel(input logic [4:0] i);
        return {i, ~i, i ^ 5'h15, ^i};
    endfunction

    function automatic logic [15:0] wpat(input logic [4:0] i);
        logic [31:0] m;
        m = (32'(i) + 32'd1) * 32'h9E37;
        return m[15:0] ^ 16'h5A5A;
    endfunction

    assign rdata = rmodel(idx);

    sbus_slave #(.DEV_ADDR(MY_DEV)) u_sbus_slave (
        .clk       (clk),
        .rst       (rst),
        .bus_sel_n (sel_n),
        .bus_clk   (bclk),
        .bus_din   (bdat),
        .bus_dout  (dout),
        .bus_doe   (doe),
        .reg_rd    (rd),
        .reg_wr    (wr),
        .reg_idx   (idx),
        .reg_wdata (wdata),
        .reg_rdata (rdata)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rd) begin rd_cnt++; rd_idx_seen = idx; end
            if (wr) begin wr_cnt++; wr_idx_seen = idx; wr_data_seen = wdata; end
            if (doe) doe_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        bclk = 1'b0;
        bdat = b;
        wait_cyc(HALF);
        bclk = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic end_sel();
        bclk = 1'b0;
        wait_cyc(HALF);
        sel_n = 1'b1;
        wait_cyc(2 * HALF);
    endtask

    task automatic txn(input logic [2:0] dev, input logic rdf,
                       input logic [4:0] ri, input logic [15:0] wd);
        int rc0, wc0, dc0;
        logic [8:0]  h;
        logic [15:0] got;
        bit mine;
        rc0 = rd_cnt; wc0 = wr_cnt; dc0 = doe_cnt;
        h = {dev, rdf, ri};
        mine = (dev == MY_DEV);
        got = '0;
        sel_n = 1'b0;
        wait_cyc(HALF);
        for (int i = 8; i >= 0; i--) pulse(h[i]);
        for (int i = 15; i >= 0; i--) begin
            pulse(rdf ? 1'b0 : wd[i]);
            got[i] = dout;
        end
        end_sel();
        if (mine && rdf) begin
            check(rd_cnt == rc0 + 1, "R3", "read strobe count", rd_cnt - rc0, 1);
            check(rd_idx_seen == ri, "R2", "read index", rd_idx_seen, ri);
            check(got == rmodel(ri), "R3", "read data shifted out", got, rmodel(ri));
            check(doe_cnt > dc0, "R6", "drive enable during read", doe_cnt - dc0, 1);
            check(wr_cnt == wc0, "R11", "no write on read", wr_cnt - wc0, 0);
        end else if (mine) begin
            check(wr_cnt == wc0 + 1, "R4", "write strobe count", wr_cnt - wc0, 1);
            check(wr_idx_seen == ri, "R2", "write index", wr_idx_seen, ri);
            check(wr_data_seen == wd, "R4", "write data", wr_data_seen, wd);
            check(rd_cnt == rc0, "R11", "no read on write", rd_cnt - rc0, 0);
            check(doe_cnt == dc0, "R6", "no drive on write", doe_cnt - dc0, 0);
        end else begin
            check(rd_cnt == rc0 && wr_cnt == wc0, "R5", "no strobe for foreign device",
                  (rd_cnt - rc0) + (wr_cnt - wc0), 0);
            check(doe_cnt == dc0, "R5", "no drive for foreign device", doe_cnt - dc0, 0);
            check(got == 16'h0, "R5", "data line quiet", got, 0);
        end
        check(doe == 1'b0, "R6", "drive released after select high", doe, 0);
    endtask

    initial begin
        int rc0, wc0;
        logic [15:0] got;
        logic [8:0]  h;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        // R1 reset state
        check(rd == 0 && wr == 0, "R1", "strobes after reset", {rd, wr}, 0);
        check(doe == 0 && dout == 0, "R1", "data pins after reset", {doe, dout}, 0);

        // R2 R3 R4 R5: every device address in both directions
        for (int d = 0; d < 8; d++) begin
            txn(3'(d), 1'b1, 5'(d * 4 + 3), 16'h0);
            txn(3'(d), 1'b0, 5'(d * 4 + 1), wpat(5'(d)));
        end

        // R2 R3 R4: full register index sweep on this device
        for (int i = 0; i < 32; i++) begin
            txn(MY_DEV, 1'b0, 5'(i), wpat(5'(i)));
            txn(MY_DEV, 1'b1, 5'(i), 16'h0);
        end

        // R7 R6: chained frames under one select
        rc0 = rd_cnt; wc0 = wr_cnt;
        sel_n = 1'b0;
        wait_cyc(HALF);
        h = {MY_DEV, 1'b0, 5'd3};
        for (int i = 8; i >= 0; i--) pulse(h[i]);
        for (int i = 15; i >= 0; i--) pulse(16'hC0DE >> i);
        h = {MY_DEV, 1'b1, 5'd12};
        for (int i = 8; i >= 0; i--) pulse(h[i]);
        got = '0;
        for (int i = 15; i >= 0; i--) begin pulse(1'b0); got[i] = dout; end
        check(doe == 1'b1, "R6", "drive held after last bit", doe, 1);
        h = {MY_DEV, 1'b0, 5'd30};
        pulse(h[8]);
        check(doe == 1'b0, "R6", "drive dropped at next edge", doe, 0);
        for (int i = 7; i >= 0; i--) pulse(h[i]);
        for (int i = 15; i >= 0; i--) pulse(16'hBEEF >> i);
        end_sel();
        check(got == rmodel(5'd12), "R7", "chained read data", got, rmodel(5'd12));
        check(rd_cnt == rc0 + 1, "R7", "chained read count", rd_cnt - rc0, 1);
        check(wr_cnt == wc0 + 2, "R7", "chained write count", wr_cnt - wc0, 2);
        check(wr_idx_seen == 5'd30 && wr_data_seen == 16'hBEEF, "R7", "third frame write",
              wr_data_seen, 16'hBEEF);

        // R8: abort mid-header
        rc0 = rd_cnt; wc0 = wr_cnt;
        sel_n = 1'b0;
        wait_cyc(HALF);
        pulse(1); pulse(0); pulse(1); pulse(1); pulse(1);
        end_sel();
        check(rd_cnt == rc0 && wr_cnt == wc0, "R8", "no strobe from aborted frame",
              (rd_cnt - rc0) + (wr_cnt - wc0), 0);
        txn(MY_DEV, 1'b0, 5'd21, 16'h0F0F);

        // R9: clock activity while deselected
        rc0 = rd_cnt; wc0 = wr_cnt;
        for (int i = 0; i < 10; i++) pulse(1'b1);
        bclk = 1'b0;
        wait_cyc(HALF);
        check(rd_cnt == rc0 && wr_cnt == wc0 && doe == 0, "R9", "edges while deselected",
              (rd_cnt - rc0) + (wr_cnt - wc0), 0);
        txn(MY_DEV, 1'b1, 5'd17, 16'h0);

        // R10: strobe latency after the final data edge
        sel_n = 1'b0;
        wait_cyc(HALF);
        h = {MY_DEV, 1'b0, 5'd9};
        for (int i = 8; i >= 0; i--) pulse(h[i]);
        for (int i = 15; i >= 1; i--) pulse(16'h8001 >> i);
        bclk = 1'b0; bdat = 1'b1;
        wait_cyc(HALF);
        bclk = 1'b1;
        @(negedge clk);
        check(wr == 1'b0, "R10", "strobe low after edge 1", wr, 0);
        @(negedge clk);
        check(wr == 1'b0, "R10", "strobe low after edge 2", wr, 0);
        @(negedge clk);
        check(wr == 1'b1 && wdata == 16'h8001, "R10", "strobe high after edge 3", wdata, 16'h8001);
        @(negedge clk);
        check(wr == 1'b0, "R10", "strobe single cycle", wr, 0);
        end_sel();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule